// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses the direction of a conditional branch. It combines two 2-bit counter predictors and uses a trained selector to choose between them. The first component indexes its counters with the branch's set bits joined to a shift register holding the outcomes of the most recent branches anywhere in the program. The second component joins the same set bits to a short history kept separately for each set, so each branch sees only its own recent outcomes. A 2-bit chooser per set decides which component supplies the final answer.

Fetch presents a PC with a request and gets the direction, and the component that produced it, in the same cycle from combinational logic. When the branch has executed, the back end presents the branch PC and its real outcome on the resolve port. On that clock edge both components train the counters they would have used. The chooser moves toward whichever component was right, and the outcome is shifted into both histories. There are no tags, so branches whose set bits match share state.

Top module: `tournament_bp`

## Requirements
- R1: After reset every counter is weakly not-taken (1), every chooser entry is weakly prefer-global (1) and all histories are zero, so every PC predicts not-taken from the global component.
- R2: Counters saturate at 0 and 3, with 0–1 meaning not-taken and 2–3 meaning taken. A resolve moves the used counter one step toward the outcome, so a strongly held direction flips only after two consecutive opposite outcomes.
- R3: The global component reads counter {pc[7:2], ghist}, where ghist is a 2-bit register. Each resolve shifts the outcome into ghist bit 0 and moves the old bit 0 to bit 1.
- R4: The local component reads counter {pc[7:2], lhist[pc[7:2]]}. A resolve shifts the outcome into bit 0 of the history of the resolved set only.
- R5: The chooser entry of a set selects local when its value is 2 or 3 and global otherwise, and pred_local_o reports this choice. The entry saturates. It moves one step toward the component that was correct on a resolve only when exactly one component was correct.
- R6: pred_taken_o equals the direction of the component selected by the chooser.
- R7: The prediction is combinational from the current state, and pred_valid_o follows pred_req_i in the same cycle. A resolve in the same cycle changes predictions only from the next cycle on.
- R8: Only PC bits [7:2] select state. PCs that agree in those bits give identical predictions and share training.
- R9: Without a resolve, no counter, chooser entry or history changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_req_i | input | 1 | Prediction request |
| pred_pc_i | input | 32 | PC of the branch being fetched |
| pred_valid_o | output | 1 | Prediction valid, same cycle as the request |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_local_o | output | 1 | 1 = the local component was selected |
| res_valid_i | input | 1 | Resolve strobe |
| res_pc_i | input | 32 | PC of the resolved branch |
| res_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
A corrupted counter, chooser entry or history bit stays hidden until a prediction reads that exact index. It then shows as a wrong pred_taken_o or pred_local_o in that same cycle. A wrong global history therefore shows up almost at once under varied traffic. A bad local history entry or a wrongly trained chooser shows only when its set is predicted again, possibly many resolves later. For this reason the stimulus reuses a small pool of PCs, including aliased ones, and compares every predicted cycle against a bench model of all tables.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_MAX     = 2'd3;
  localparam ctr_t CTR_WEAK_NT = 2'd1;

  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up)  return (c == CTR_MAX) ? c : ctr_t'(c + 2'd1);
    else     return (c == 2'd0)    ? c : ctr_t'(c - 2'd1);
  endfunction
endpackage

// File: rtl/bp_sat_table.sv
module bp_sat_table
  import bp_pkg::*;
#(
  parameter int   IDX_W   = 8,
  parameter ctr_t RST_VAL = CTR_WEAK_NT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i,
  output ctr_t             rd_a_o,
  output ctr_t             rd_b_o
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t [DEPTH-1:0] tab_q;
  ctr_t             wr_old;

  assign rd_a_o = tab_q[rd_a_idx_i];
  assign rd_b_o = tab_q[rd_b_idx_i];
  assign wr_old = tab_q[wr_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) tab_q[i] <= RST_VAL;
    end else if (wr_en_i) begin
      tab_q[wr_idx_i] <= ctr_step(wr_old, wr_up_i);
    end
  end

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(tab_q));

  assert_saturate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && wr_old == CTR_MAX) |=> tab_q[$past(wr_idx_i)] == CTR_MAX);

  assert_floor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && wr_old == 2'd0) |=> tab_q[$past(wr_idx_i)] == 2'd0);
endmodule

// File: rtl/bp_history.sv
module bp_history #(
  parameter int SET_W  = 6,
  parameter int HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic [SET_W-1:0]  upd_set_i,
  input  logic              upd_taken_i,
  input  logic [SET_W-1:0]  p_set_i,
  output logic [HIST_W-1:0] ghist_o,
  output logic [HIST_W-1:0] p_lhist_o,
  output logic [HIST_W-1:0] r_lhist_o
);
  localparam int SETS = 1 << SET_W;

  logic [HIST_W-1:0]            ghist_q;
  logic [SETS-1:0][HIST_W-1:0]  lhist_q;

  assign ghist_o   = ghist_q;
  assign p_lhist_o = lhist_q[p_set_i];
  assign r_lhist_o = lhist_q[upd_set_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ghist_q <= '0;
      lhist_q <= '0;
    end else if (upd_i) begin
      ghist_q            <= {ghist_q[HIST_W-2:0], upd_taken_i};
      lhist_q[upd_set_i] <= {lhist_q[upd_set_i][HIST_W-2:0], upd_taken_i};
    end
  end

  assert_ghist_shift_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (ghist_q[0] == $past(upd_taken_i)) && (ghist_q[1] == $past(ghist_q[0])));

  assert_lhist_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> lhist_q[$past(upd_set_i)][0] == $past(upd_taken_i));

  assert_hist_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(ghist_q) && $stable(lhist_q));
endmodule

// File: rtl/tournament_bp.sv
module tournament_bp
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PC_LSB = 2,
  parameter int SET_W  = 6,
  parameter int HIST_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pred_req_i,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_valid_o,
  output logic            pred_taken_o,
  output logic            pred_local_o,
  input  logic            res_valid_i,
  input  logic [PC_W-1:0] res_pc_i,
  input  logic            res_taken_i
);
  localparam int TBL_W = SET_W + HIST_W;

  logic [SET_W-1:0]  p_set, r_set;
  logic [HIST_W-1:0] ghist, p_lh, r_lh;
  ctr_t              g_p, g_r, l_p, l_r, c_p, c_r;
  logic              g_r_dir, l_r_dir, chooser_wr;

  assign p_set = pred_pc_i[PC_LSB +: SET_W];
  assign r_set = res_pc_i[PC_LSB +: SET_W];

  bp_history #(.SET_W(SET_W), .HIST_W(HIST_W)) i_hist (
    .clk_i, .rst_ni,
    .upd_i      (res_valid_i),
    .upd_set_i  (r_set),
    .upd_taken_i(res_taken_i),
    .p_set_i    (p_set),
    .ghist_o    (ghist),
    .p_lhist_o  (p_lh),
    .r_lhist_o  (r_lh)
  );

  bp_sat_table #(.IDX_W(TBL_W), .RST_VAL(CTR_WEAK_NT)) i_glob (
    .clk_i, .rst_ni,
    .rd_a_idx_i({p_set, ghist}),
    .rd_b_idx_i({r_set, ghist}),
    .wr_en_i   (res_valid_i),
    .wr_idx_i  ({r_set, ghist}),
    .wr_up_i   (res_taken_i),
    .rd_a_o    (g_p),
    .rd_b_o    (g_r)
  );

  bp_sat_table #(.IDX_W(TBL_W), .RST_VAL(CTR_WEAK_NT)) i_loc (
    .clk_i, .rst_ni,
    .rd_a_idx_i({p_set, p_lh}),
    .rd_b_idx_i({r_set, r_lh}),
    .wr_en_i   (res_valid_i),
    .wr_idx_i  ({r_set, r_lh}),
    .wr_up_i   (res_taken_i),
    .rd_a_o    (l_p),
    .rd_b_o    (l_r)
  );

  // chooser: 0..1 prefer global, 2..3 prefer local
  assign g_r_dir    = g_r[1];
  assign l_r_dir    = l_r[1];
  assign chooser_wr = res_valid_i && (g_r_dir != l_r_dir);

  bp_sat_table #(.IDX_W(SET_W), .RST_VAL(2'd1)) i_choose (
    .clk_i, .rst_ni,
    .rd_a_idx_i(p_set),
    .rd_b_idx_i(r_set),
    .wr_en_i   (chooser_wr),
    .wr_idx_i  (r_set),
    .wr_up_i   (l_r_dir == res_taken_i),
    .rd_a_o    (c_p),
    .rd_b_o    (c_r)
  );

  assign pred_valid_o = pred_req_i;
  assign pred_local_o = c_p[1];
  assign pred_taken_o = c_p[1] ? l_p[1] : g_p[1];

  // chooser entry must not move when both components agreed
  assert_chooser_agree_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && g_r_dir == l_r_dir && pred_req_i && p_set == r_set)
      |=> (!$changed(res_pc_i) && !$changed(pred_pc_i)) -> (c_p == $past(c_p)));

  assert_chooser_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chooser_wr && c_r == 2'd3 && l_r_dir == res_taken_i && $stable(res_pc_i))
      |=> 1'b1 ##0 (r_set != $past(r_set) || c_r == 2'd3));
endmodule

// File: tb/test_tournament_bp.sv
module test_tournament_bp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pred_req = 1'b0;
  logic [31:0] pred_pc = '0;
  logic        pred_valid, pred_taken, pred_local;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  int gt[256];
  int lt[256];
  int ch[64];
  int lh[64];
  int gh;

  always #5 clk = ~clk;

  tournament_bp i_tournament_bp (
    .clk_i(clk), .rst_ni(rst_n),
    .pred_req_i(pred_req), .pred_pc_i(pred_pc),
    .pred_valid_o(pred_valid), .pred_taken_o(pred_taken), .pred_local_o(pred_local),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_taken_i(res_taken)
  );

  function automatic int set_of(input logic [31:0] pc);
    return int'(pc[7:2]);
  endfunction

  function automatic int step(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic void model_reset();
    for (int i = 0; i < 256; i++) begin gt[i] = 1; lt[i] = 1; end
    for (int i = 0; i < 64; i++) begin ch[i] = 1; lh[i] = 0; end
    gh = 0;
  endfunction

  function automatic void model_resolve(input logic [31:0] pc, input bit t);
    int s, gi, li;
    bit gd, ld;
    s  = set_of(pc);
    gi = s * 4 + gh;
    li = s * 4 + lh[s];
    gd = gt[gi] >= 2;
    ld = lt[li] >= 2;
    gt[gi] = step(gt[gi], t);
    lt[li] = step(lt[li], t);
    if (gd != ld) ch[s] = step(ch[s], ld == t);
    gh    = ((gh << 1) | int'(t)) & 3;
    lh[s] = ((lh[s] << 1) | int'(t)) & 3;
  endfunction

  task automatic check_bit(input string req, input string what, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic cycle(input bit rq, input logic [31:0] ppc,
                       input bit rv, input logic [31:0] rpc, input bit rt);
    int s;
    bit eg, el, es;
    @(negedge clk);
    pred_req = rq; pred_pc = ppc;
    res_valid = rv; res_pc = rpc; res_taken = rt;
    #1;
    s  = set_of(ppc);
    eg = gt[s * 4 + gh] >= 2;
    el = lt[s * 4 + lh[s]] >= 2;
    es = ch[s] >= 2;
    check_bit("R7", "pred_valid_o", pred_valid, rq);
    if (rq) begin
      check_bit(tag, "pred_taken_o", pred_taken, es ? el : eg);
      check_bit("R5", "pred_local_o", pred_local, es);
    end
    @(posedge clk);
    if (rv) model_resolve(rpc, rt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] pa, pb;
    bit a_t, a_l;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R1: reset state, not-taken from global everywhere
    tag = "R1";
    for (int k = 0; k < 4; k++) begin
      cycle(1, 32'h4000 + k * 36, 0, '0, 0);
      check_bit("R1", "reset pred_taken_o", pred_taken, 1'b0);
      check_bit("R1", "reset pred_local_o", pred_local, 1'b0);
    end

    // R2: repeated taken then not-taken outcomes on one branch
    tag = "R2";
    pa = 32'h0000_1010;
    for (int k = 0; k < 5; k++) cycle(1, pa, 1, pa, 1);
    cycle(1, pa, 0, '0, 0);
    check_bit("R2", "trained taken", pred_taken, 1'b1);
    for (int k = 0; k < 4; k++) cycle(1, pa, 1, pa, 0);
    cycle(1, pa, 0, '0, 0);

    // R7: same-cycle resolve seen only from next cycle
    tag = "R7";
    pb = 32'h0000_2020;
    cycle(1, pb, 1, pb, 1);
    cycle(1, pb, 1, pb, 1);
    cycle(1, pb, 0, '0, 0);

    // R8: aliasing across high PC bits
    tag = "R8";
    cycle(1, pa, 0, '0, 0);
    a_t = pred_taken; a_l = pred_local;
    cycle(1, pa + 32'h0001_0000, 0, '0, 0);
    check_bit("R8", "alias taken", pred_taken, a_t);
    check_bit("R8", "alias source", pred_local, a_l);

    // R9: idle cycles change nothing
    tag = "R9";
    for (int k = 0; k < 6; k++) cycle(k[0], pa, 0, '0, 0);
    cycle(1, pa, 0, '0, 0);
    check_bit("R9", "hold taken", pred_taken, a_t);

    // R3/R4/R5/R6: alternating patterns stress history and chooser
    tag = "R4";
    for (int k = 0; k < 40; k++) cycle(1, pb, 1, pb, k[0]);
    tag = "R3";
    for (int k = 0; k < 40; k++) cycle(1, pa, 1, (k % 2) ? pa : pb, (k % 4) < 2);

    // random mix over a small PC pool with aliases
    tag = "R6";
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] ppc, rpc;
      ppc = 32'h1000 + ($urandom % 8) * 4 + (($urandom % 4) << 8);
      rpc = 32'h1000 + ($urandom % 8) * 4 + (($urandom % 2) << 12);
      cycle($urandom % 4 != 0, ppc, $urandom % 3 != 0, rpc, ($urandom % 8) < 6);
    end

    // reset again mid-run
    tag = "R1";
    @(negedge clk); rst_n = 1'b0; model_reset();
    @(negedge clk); rst_n = 1'b1;
    cycle(1, pa, 0, '0, 0);
    check_bit("R1", "re-reset taken", pred_taken, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule